// File: doc/BRIEF.md
# Ping-Pong Response Transmit Buffer

This block holds response bytes coming in from a serial daisy-chain receiver until a host drains them through an SPI slave shifter. Storage is split into two equal banks that swap roles. One bank takes bytes from the chain while the host reads the other. A bank is handed back to the writer only after the reader has consumed every location in it. Each location the host reads is rewritten with 0xFF, so a drained bank is clean.

The chain side presents one byte per cycle with a valid strobe. The SPI side pulses a pop strobe once per byte, and the byte appears on the read port one cycle later. Status outputs give the ready-flag logic what it needs: the bank under read, a one-cycle pulse when a bank fills, a level that shows the bank under read has nothing unread, and a sticky overrun flag. A synchronous clear discards everything.

Top module: `ppbuf_top`

## Requirements
- R1: After reset or a clear cycle, read_bank is 0, read_empty is 1, overrun is 0, bank_full is 0 and host_byte is 0xFF. Data stored before the clear is gone.
- R2: Accepted chain bytes come out on host_byte in arrival order, across any number of bank swaps. host_byte is valid in the cycle after the pop.
- R3: bank_full is high for exactly one cycle. That cycle is the one after the edge that stores the byte filling a bank's last location.
- R4: The writer uses the other bank only when that bank holds zero bytes. The reader moves to the other bank, toggling read_bank, right after it pops the last location of a full bank.
- R5: A byte arriving when the fill bank is full and the other bank still holds data is dropped. overrun then goes high and stays high until reset or clear.
- R6: A pop while read_empty is 1 does not advance the read position. host_byte shows 0xFF after that pop.
- R7: Every consumed location holds 0xFF afterwards. A pop on an empty bank whose slots were used before still returns 0xFF, not stale data.
- R8: read_empty is 1 exactly when the bank under read has no unread byte. For example, a partly filled bank is empty once its stored bytes are read.
- R9: A chain byte and a pop in the same cycle are both serviced, including when both touch the same bank.
- R10: Clear takes priority over a chain byte or a pop presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous discard of all contents |
| chain_vld | input | 1 | Chain byte strobe |
| chain_byte | input | 8 | Chain byte |
| host_pop | input | 1 | Host consumes one byte |
| host_byte | output | 8 | Byte returned for the last pop |
| read_bank | output | 1 | Bank under read |
| bank_full | output | 1 | One-cycle pulse when a bank fills |
| read_empty | output | 1 | Bank under read has nothing unread |
| overrun | output | 1 | Sticky drop indicator |

## Verification
The bench targets several edge cases that are easy to get wrong:
- Popping the last slot of a full bank while a new byte arrives. A design that hands the released bank back too early would write into the bank the reader just left, so later bytes would come out of order.
- A pop on a drained bank. Without the 0xFF write-back this returns stale bytes from the previous pass.
- A byte arriving while both banks are busy. A faulty design would overwrite unread data instead of dropping the byte and setting overrun.
- Chasing reads on a partly filled bank, which exercise read_empty. Random streams with varying pop rates and occasional clears mix all of these cases.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t FILL_BYTE = 8'hFF;

  function automatic logic other_bank(input logic b);
    return ~b;
  endfunction

  function automatic logic [1:0] bank_sel(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/ppbuf_bank.sv
module ppbuf_bank
  import ppbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  byte_t         wr_data,
  input  logic          scrub_en,
  input  logic [AW-1:0] scrub_addr,
  input  logic [AW-1:0] rd_addr,
  output byte_t         rd_data
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL_BYTE;
    end else if (clear) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL_BYTE;
    end else begin
      if (wr_en)    mem[wr_addr]    <= wr_data;
      if (scrub_en) mem[scrub_addr] <= FILL_BYTE;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ppbuf_wr_ctrl.sv
module ppbuf_wr_ctrl
  import ppbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               in_vld,
  input  logic [1:0]         release_vec,
  output logic [1:0][CW-1:0] fill_cnt,
  output logic [1:0]         we_vec,
  output logic [AW-1:0]      wr_addr,
  output logic               drop_evt,
  output logic               full_pulse,
  output logic               overrun
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          fill_bank;
  logic [CW-1:0] cur_cnt, alt_cnt, next_cnt;
  logic          room, can_swap, accept, tgt, full_evt;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic fresh);
    return (fresh ? '0 : c) + 1'b1;
  endfunction

  always_comb begin
    cur_cnt  = fill_cnt[fill_bank];
    alt_cnt  = fill_cnt[other_bank(fill_bank)];
    room     = (cur_cnt != FULL_CNT);
    can_swap = !room && (alt_cnt == '0);
    accept   = in_vld && (room || can_swap);
    drop_evt = in_vld && !room && !can_swap;
    tgt      = room ? fill_bank : other_bank(fill_bank);
    wr_addr  = room ? cur_cnt[AW-1:0] : '0;
    we_vec   = accept ? bank_sel(tgt) : 2'b00;
    next_cnt = bump(cur_cnt, !room);
    full_evt = accept && (next_cnt == FULL_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt   <= '0;
      fill_bank  <= 1'b0;
      full_pulse <= 1'b0;
      overrun    <= 1'b0;
    end else if (clear) begin
      fill_cnt   <= '0;
      fill_bank  <= 1'b0;
      full_pulse <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (release_vec[b])  fill_cnt[b] <= '0;
        else if (we_vec[b])  fill_cnt[b] <= fill_cnt[b] + 1'b1;
      end
      if (accept)                      fill_bank <= tgt;
      else if (release_vec[fill_bank]) fill_bank <= other_bank(fill_bank);
      full_pulse <= full_evt;
      overrun    <= overrun | drop_evt;
    end
  end
endmodule

// File: rtl/ppbuf_rd_ctrl.sv
module ppbuf_rd_ctrl
  import ppbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               pop,
  input  logic [1:0][CW-1:0] fill_cnt,
  output logic               read_bank,
  output logic [AW-1:0]      rd_addr,
  output logic [1:0]         scrub_vec,
  output logic [1:0]         release_vec,
  output logic               take_evt,
  output logic               idle_evt,
  output logic               empty
);
  localparam logic [CW-1:0] LAST_POS = CW'(DEPTH - 1);

  logic [CW-1:0] rptr;
  logic          last;

  function automatic logic unread_none(input logic [CW-1:0] cnt, input logic [CW-1:0] pos);
    return cnt == pos;
  endfunction

  always_comb begin
    empty       = unread_none(fill_cnt[read_bank], rptr);
    last        = (rptr == LAST_POS);
    take_evt    = pop && !empty;
    idle_evt    = pop && empty;
    scrub_vec   = take_evt ? bank_sel(read_bank) : 2'b00;
    release_vec = (take_evt && last) ? bank_sel(read_bank) : 2'b00;
    rd_addr     = rptr[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_bank <= 1'b0;
      rptr      <= '0;
    end else if (clear) begin
      read_bank <= 1'b0;
      rptr      <= '0;
    end else if (take_evt) begin
      if (last) begin
        read_bank <= other_bank(read_bank);
        rptr      <= '0;
      end else begin
        rptr <= rptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppbuf_top.sv
module ppbuf_top
  import ppbuf_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       chain_vld,
  input  logic [7:0] chain_byte,
  input  logic       host_pop,
  output logic [7:0] host_byte,
  output logic       read_bank,
  output logic       bank_full,
  output logic       read_empty,
  output logic       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0][CW-1:0] fill_cnt;
  logic [1:0]         we_vec, scrub_vec, release_vec;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic               drop_evt, take_evt, idle_evt;
  byte_t              bank_out [2];

  ppbuf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_vld(chain_vld),
    .release_vec(release_vec), .fill_cnt(fill_cnt), .we_vec(we_vec),
    .wr_addr(wr_addr), .drop_evt(drop_evt), .full_pulse(bank_full),
    .overrun(overrun)
  );

  ppbuf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .clear(clear), .pop(host_pop),
    .fill_cnt(fill_cnt), .read_bank(read_bank), .rd_addr(rd_addr),
    .scrub_vec(scrub_vec), .release_vec(release_vec), .take_evt(take_evt),
    .idle_evt(idle_evt), .empty(read_empty)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ppbuf_bank #(.DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .wr_en(we_vec[b]), .wr_addr(wr_addr), .wr_data(chain_byte),
      .scrub_en(scrub_vec[b]), .scrub_addr(rd_addr),
      .rd_addr(rd_addr), .rd_data(bank_out[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        host_byte <= FILL_BYTE;
    else if (clear)    host_byte <= FILL_BYTE;
    else if (host_pop) host_byte <= bank_out[read_bank];
  end
endmodule

// File: rtl/ppbuf_chk.sv
module ppbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clear,
  input logic [7:0] host_byte,
  input logic       read_bank,
  input logic       read_empty,
  input logic       bank_full,
  input logic       overrun,
  input logic       drop_evt,
  input logic [1:0] we_vec,
  input logic [1:0] release_vec,
  input logic       take_evt,
  input logic       idle_evt
);
  assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (read_empty && !overrun && !read_bank && host_byte == 8'hFF));

  assert_full_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_full |=> !bank_full);

  assert_swap_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|release_vec) && !clear) |=> (read_bank != $past(read_bank)));

  assert_drop_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (we_vec == 2'b00));

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clear) |=> overrun);

  assert_idle_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && !clear) |=> (host_byte == 8'hFF));

  assert_empty_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_empty |-> !take_evt);

  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
endmodule

bind ppbuf_top ppbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .host_byte(host_byte),
  .read_bank(read_bank), .read_empty(read_empty), .bank_full(bank_full),
  .overrun(overrun), .drop_evt(drop_evt), .we_vec(we_vec),
  .release_vec(release_vec), .take_evt(take_evt), .idle_evt(idle_evt)
);

// File: tb/test_ppbuf_top.sv
module test_ppbuf_top;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       chain_vld = 1'b0;
  logic [7:0] chain_byte = 8'h00;
  logic       host_pop = 1'b0;
  logic [7:0] host_byte;
  logic       read_bank, bank_full, read_empty, overrun;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string ctx = "";

  // bench model state
  logic [7:0] m_data [2][D];
  int  m_cnt [2];
  int  m_fill, m_read, m_rpos;
  bit  m_ovr, m_full;
  logic [7:0] m_byte;
  bit  m_took;

  always #2 clk = ~clk;

  ppbuf_top #(.DEPTH(D)) i_ppbuf_top (
    .clk(clk), .rst_n(rst_n), .clear(clear), .chain_vld(chain_vld),
    .chain_byte(chain_byte), .host_pop(host_pop), .host_byte(host_byte),
    .read_bank(read_bank), .bank_full(bank_full), .read_empty(read_empty),
    .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, ctx, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_cnt[0] = 0; m_cnt[1] = 0;
    m_fill = 0; m_read = 0; m_rpos = 0;
    m_ovr = 0; m_full = 0; m_byte = 8'hFF; m_took = 0;
  endfunction

  function automatic bit model_empty();
    return m_cnt[m_read] == m_rpos;
  endfunction

  // one cycle of the reference behaviour, evaluated on the state before the edge
  function automatic void model_step(input bit v, input logic [7:0] d, input bit p, input bit c);
    int pre_cnt [2];
    int rel;
    if (c) begin
      model_reset();
      return;
    end
    pre_cnt[0] = m_cnt[0]; pre_cnt[1] = m_cnt[1];
    rel = -1;
    m_full = 0;
    m_took = 0;
    if (p) begin
      if (pre_cnt[m_read] > m_rpos) begin
        m_byte = m_data[m_read][m_rpos];
        m_took = 1;
        m_rpos++;
        if (m_rpos == D) begin
          rel = m_read;
          m_read = 1 - m_read;
          m_rpos = 0;
        end
      end else begin
        m_byte = 8'hFF;
      end
    end
    if (v) begin
      if (pre_cnt[m_fill] < D) begin
        m_data[m_fill][pre_cnt[m_fill]] = d;
        m_cnt[m_fill] = pre_cnt[m_fill] + 1;
        if (m_cnt[m_fill] == D) m_full = 1;
      end else if (pre_cnt[1 - m_fill] == 0) begin
        m_fill = 1 - m_fill;
        m_data[m_fill][0] = d;
        m_cnt[m_fill] = 1;
        if (D == 1) m_full = 1;
      end else begin
        m_ovr = 1;
      end
    end
    if (rel >= 0) begin
      m_cnt[rel] = 0;
      if (rel == m_fill) m_fill = 1 - m_fill;
    end
  endfunction

  task automatic step(input bit v, input logic [7:0] d, input bit p, input bit c);
    bit was_empty;
    @(negedge clk);
    chain_vld = v; chain_byte = d; host_pop = p; clear = c;
    was_empty = model_empty();
    model_step(v, d, p, c);
    @(posedge clk);
    #1;
    if (c)                     chk("R10", host_byte, m_byte);
    else if (p && m_took)      chk("R2", host_byte, m_byte);
    else if (p && was_empty)   chk("R6", host_byte, m_byte);
    else                       chk("R2", host_byte, m_byte);
    chk("R3", bank_full, m_full);
    chk("R5", overrun, m_ovr);
    chk("R4", read_bank, m_read);
    chk("R8", read_empty, model_empty());
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    ctx = "reset";
    chk("R1", host_byte, 8'hFF);
    chk("R1", read_bank, 0);
    chk("R1", read_empty, 1);
    chk("R1", overrun, 0);
    chk("R1", bank_full, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: pop on empty after reset
    ctx = "empty pop";
    step(0, 0, 1, 0);
    chk("R6", host_byte, 8'hFF);

    // R8: partial bank drained by chasing reads
    ctx = "partial";
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0);
    chk("R8", read_empty, 1);

    // R3, R4: fill bank 0, spill into bank 1, drain bank 0
    ctx = "swap";
    for (int i = 0; i < 2*D - 5; i++) step(1, 8'h40 + 8'(i), 0, 0);
    for (int i = 0; i < D - 5; i++) step(0, 0, 1, 0);
    chk("R4", read_bank, 1);

    // R5: overrun with both banks busy
    ctx = "overrun";
    for (int i = 0; i < D; i++) step(1, 8'hA0 + 8'(i), 0, 0);
    step(1, 8'hEE, 0, 0);
    chk("R5", overrun, 1);

    // R9: read and write together while bank 1 drains
    ctx = "R9 concurrent";
    for (int i = 0; i < D; i++) step(1, 8'hC0 + 8'(i), 1, 0);
    for (int i = 0; i < 2*D; i++) step(0, 0, 1, 0);

    // R7: empty pop on a previously used slot returns the fill value
    ctx = "R7 scrub";
    step(0, 0, 1, 0);
    chk("R7", host_byte, 8'hFF);

    // R10: clear beats a simultaneous byte and pop
    ctx = "clear";
    step(1, 8'h55, 0, 0);
    step(1, 8'h66, 1, 1);
    chk("R1", read_empty, 1);
    chk("R10", overrun, 0);

    // random phase
    void'($urandom(32'h1234_5678));
    for (int blk = 0; blk < 40; blk++) begin
      int pr, vr;
      ctx = "random";
      pr = 20 + int'($urandom_range(0, 70));
      vr = 20 + int'($urandom_range(0, 70));
      for (int i = 0; i < 500; i++) begin
        step(($urandom_range(0, 99) < vr), 8'($urandom),
             ($urandom_range(0, 99) < pr), ($urandom_range(0, 999) == 0));
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule